// File: doc/BRIEF.md
# Multi-Context Reservation Monitor for Load-Locked / Store-Conditional

This block holds one address reservation for each hardware thread context and decides whether store-conditional atomics succeed. A single arbitrated request port accepts at most one request per cycle. Each request names a context, an operation (load-locked, store-conditional or ordinary store), a physical address and an uncacheable flag. A load-locked request records the address of an aligned 16-byte block for its context. A store-conditional is checked against the issuing context's reservation and answered with a 2-bit result code. Every store that reaches memory clears the reservations of all contexts that hold the same block.

The monitor does not carry the store data. It grants or withholds the write through a one-cycle `wr_grant` strobe, and the memory path beside it acts on that strobe. Each context also counts its consecutive store-conditional failures. Every time that count reaches a multiple of `WARN_EVERY` (default 100000), the block emits a one-cycle warning tagged with the context, so that software-level livelock can be flagged.

The request port uses valid/ready. `req_ready` is low while reset is asserted and high from the first clock after reset. A request is accepted on any rising edge where both `req_valid` and `req_ready` are high. The result side has no back-pressure: `rsp_valid`, `wr_grant` and `warn_pulse` are strobes that are each high for exactly one cycle.

Top module: `resv_monitor`

## Requirements
- R1: A load-locked request (`req_op`=1) stores the block of `req_addr` for its context and sets that context's reservation flag. A second load-locked from the same context replaces the stored block, and the flag stays set.
- R2: Address bits [3:0] take no part in any comparison. A reservation covers the aligned 16-byte block, and addresses in other blocks never match it.
- R3: A cacheable store-conditional (`req_op`=2, `req_uncached`=0) whose context has a clear flag, or a different stored block, fails. It returns code 0, gives no `wr_grant`, and clears that context's flag.
- R4: A cacheable store-conditional whose context holds a matching reservation returns code 1, raises `wr_grant`, and resets that context's consecutive-failure count.
- R5: An uncacheable store-conditional ignores reservations. It returns code 2, raises `wr_grant`, and resets its context's consecutive-failure count.
- R6: Every granted write clears the flag of every context, the issuer included, whose stored block equals the written block. Granted writes are ordinary stores (`req_op`=3) and store-conditionals that return code 1 or 2. Reservations on other blocks survive.
- R7: A failed store-conditional leaves the reservations of all other contexts unchanged.
- R8: Each failed store-conditional increments its context's count. When the new count is a non-zero multiple of `WARN_EVERY`, `warn_pulse` is high for one cycle and `warn_ctx` carries the context index.
- R9: Reset clears all flags and failure counts, holds `req_ready` low, and keeps all strobes low.
- R10: `rsp_valid`, `rsp_code`, `rsp_ctx`, `wr_grant` and `warn_pulse` update on the same edge that accepts the request. The reservation changes caused by a request are visible to a request accepted on the very next edge.
- R11: Only store-conditionals raise `rsp_valid`. An ordinary store raises `wr_grant` without a response, a load-locked raises neither, and code 3 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request port can accept |
| req_ctx | input | CW | Issuing context index |
| req_op | input | 2 | 0 none, 1 load-locked, 2 store-conditional, 3 ordinary store |
| req_addr | input | AW | Physical address |
| req_uncached | input | 1 | Access is uncacheable |
| rsp_valid | output | 1 | Store-conditional result strobe |
| rsp_code | output | 2 | 0 fail, 1 success, 2 uncacheable success |
| rsp_ctx | output | CW | Context the result belongs to |
| wr_grant | output | 1 | Memory write permitted for the accepted request |
| warn_pulse | output | 1 | Consecutive-failure warning strobe |
| warn_ctx | output | CW | Context that raised the warning |

## Verification
Every result of this block is due one cycle after its stimulus. This covers the response code, the write grant and the failure warning, which all appear on the rising edge that accepts the request. The bench drives each request at the falling edge and samples all outputs 1 ns after the accepting rising edge, so each value is read in the single cycle it is valid. Requests are issued back to back, which shows that a reservation set, replaced or cleared by one request already governs the next. Reservation state cannot be read at the ports, so the bench probes it with a follow-up store-conditional whose code reveals whether the flag survived.

// File: rtl/resv_pkg.sv
package resv_pkg;
  localparam int BLK_BITS = 4;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_LL   = 2'd1,
    OP_SC   = 2'd2,
    OP_ST   = 2'd3
  } req_op_e;

  localparam logic [1:0] RES_FAIL = 2'd0;
  localparam logic [1:0] RES_OK   = 2'd1;
  localparam logic [1:0] RES_UNC  = 2'd2;
endpackage

// File: rtl/resv_slot.sv
module resv_slot
  import resv_pkg::*;
#(
  parameter int AW         = 40,
  parameter int WARN_EVERY = 100000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-BLK_BITS-1:0] req_blk,
  input  logic               ll_set,
  input  logic               sc_fail,
  input  logic               sc_pass,
  input  logic               wr_go,
  output logic               blk_hit,
  output logic               held,
  output logic               warn
);
  localparam int BW = AW - BLK_BITS;
  localparam int PW = $clog2(WARN_EVERY + 1);
  localparam logic [PW-1:0] LAST = PW'(WARN_EVERY - 1);

  logic          flag_q;
  logic [BW-1:0] blk_q;
  logic [PW-1:0] phase_q;
  logic          warn_q;

  assign blk_hit = flag_q && (blk_q == req_blk);
  assign held    = flag_q;
  assign warn    = warn_q;

  // reservation register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      blk_q  <= '0;
    end else if (ll_set) begin
      flag_q <= 1'b1;
      blk_q  <= req_blk;
    end else if (sc_fail) begin
      flag_q <= 1'b0;
    end else if (wr_go && blk_hit) begin
      flag_q <= 1'b0;
    end
  end

  // consecutive failure phase counter, wraps at WARN_EVERY
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      warn_q  <= 1'b0;
    end else begin
      warn_q <= 1'b0;
      if (sc_fail) begin
        if (phase_q == LAST) begin
          phase_q <= '0;
          warn_q  <= 1'b1;
        end else begin
          phase_q <= phase_q + 1'b1;
        end
      end else if (sc_pass) begin
        phase_q <= '0;
      end
    end
  end
endmodule

// File: rtl/resv_req_decode.sv
module resv_req_decode
  import resv_pkg::*;
#(
  parameter int NCTX = 4,
  parameter int CW   = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input  logic            acc,
  input  logic [1:0]      op,
  input  logic            uncached,
  input  logic [CW-1:0]   ctx,
  input  logic            own_hit,
  output logic [NCTX-1:0] ll_vec,
  output logic [NCTX-1:0] fail_vec,
  output logic [NCTX-1:0] pass_vec,
  output logic            wr_go,
  output logic            sc_go,
  output logic [1:0]      code
);
  logic is_ll, is_sc, is_st, sc_ok;

  assign is_ll = acc && (op == OP_LL);
  assign is_sc = acc && (op == OP_SC);
  assign is_st = acc && (op == OP_ST);
  assign sc_ok = is_sc && (uncached || own_hit);

  assign sc_go = is_sc;
  assign wr_go = is_st || sc_ok;

  always_comb begin
    if (uncached)     code = RES_UNC;
    else if (own_hit) code = RES_OK;
    else              code = RES_FAIL;
  end

  for (genvar i = 0; i < NCTX; i++) begin : g_sel
    logic mine;
    assign mine        = (ctx == CW'(i));
    assign ll_vec[i]   = is_ll && mine;
    assign fail_vec[i] = is_sc && !sc_ok && mine;
    assign pass_vec[i] = sc_ok && mine;
  end
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int NCTX       = 4,
  parameter int AW         = 40,
  parameter int WARN_EVERY = 100000,
  parameter int CW         = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [CW-1:0] req_ctx,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic          req_uncached,
  output logic          rsp_valid,
  output logic [1:0]    rsp_code,
  output logic [CW-1:0] rsp_ctx,
  output logic          wr_grant,
  output logic          warn_pulse,
  output logic [CW-1:0] warn_ctx
);
  localparam int BW = AW - BLK_BITS;

  logic            ready_q;
  logic            acc;
  logic [BW-1:0]   req_blk;
  logic            unused_low;
  logic [NCTX-1:0] hit_vec, held_vec, warn_vec;
  logic [NCTX-1:0] ll_vec, fail_vec, pass_vec;
  logic            own_hit, wr_go, sc_go;
  logic [1:0]      code;

  assign req_blk    = req_addr[AW-1:BLK_BITS];
  assign unused_low = ^req_addr[BLK_BITS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign req_ready = ready_q;
  assign acc       = req_valid && ready_q;

  assign own_hit = hit_vec[req_ctx];

  resv_req_decode #(.NCTX(NCTX), .CW(CW)) u_dec (
    .acc      (acc),
    .op       (req_op),
    .uncached (req_uncached),
    .ctx      (req_ctx),
    .own_hit  (own_hit),
    .ll_vec   (ll_vec),
    .fail_vec (fail_vec),
    .pass_vec (pass_vec),
    .wr_go    (wr_go),
    .sc_go    (sc_go),
    .code     (code)
  );

  for (genvar i = 0; i < NCTX; i++) begin : g_slot
    resv_slot #(.AW(AW), .WARN_EVERY(WARN_EVERY)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_blk (req_blk),
      .ll_set  (ll_vec[i]),
      .sc_fail (fail_vec[i]),
      .sc_pass (pass_vec[i]),
      .wr_go   (wr_go),
      .blk_hit (hit_vec[i]),
      .held    (held_vec[i]),
      .warn    (warn_vec[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_code  <= RES_FAIL;
      rsp_ctx   <= '0;
      wr_grant  <= 1'b0;
    end else begin
      rsp_valid <= sc_go;
      wr_grant  <= wr_go;
      if (sc_go) begin
        rsp_code <= code;
        rsp_ctx  <= req_ctx;
      end
    end
  end

  // at most one warning per cycle, one request per cycle
  always_comb begin
    warn_ctx = '0;
    for (int i = 0; i < NCTX; i++)
      if (warn_vec[i]) warn_ctx = warn_ctx | CW'(i);
  end
  assign warn_pulse = |warn_vec;
endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk
  import resv_pkg::*;
#(
  parameter int NCTX = 4,
  parameter int CW   = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [CW-1:0]   req_ctx,
  input logic [1:0]      req_op,
  input logic            req_uncached,
  input logic            rsp_valid,
  input logic [1:0]      rsp_code,
  input logic [CW-1:0]   rsp_ctx,
  input logic            wr_grant,
  input logic            warn_pulse,
  input logic [CW-1:0]   warn_ctx,
  input logic [NCTX-1:0] held
);
  logic acc;
  assign acc = req_valid && req_ready;

  always_comb begin
    if (!rst_n) assert_reset_quiet_R9: assert (!rsp_valid && !wr_grant && !warn_pulse);
  end

  assert_ll_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_op == OP_LL |=> held[$past(req_ctx)]);

  assert_fail_nowrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_code == RES_FAIL |-> !wr_grant);

  assert_pass_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_code != RES_FAIL |-> wr_grant);

  assert_unc_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_op == OP_SC && req_uncached |=> rsp_valid && rsp_code == RES_UNC);

  assert_warn_on_fail_R8: assert property (@(posedge clk) disable iff (!rst_n)
    warn_pulse |-> rsp_valid && rsp_code == RES_FAIL && warn_ctx == rsp_ctx);

  assert_rsp_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_op == OP_SC |=> rsp_valid && rsp_ctx == $past(req_ctx));

  assert_rsp_only_sc_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(acc && req_op == OP_SC) && rsp_code != 2'd3);
endmodule

bind resv_monitor resv_monitor_chk #(.NCTX(NCTX), .CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_ctx      (req_ctx),
  .req_op       (req_op),
  .req_uncached (req_uncached),
  .rsp_valid    (rsp_valid),
  .rsp_code     (rsp_code),
  .rsp_ctx      (rsp_ctx),
  .wr_grant     (wr_grant),
  .warn_pulse   (warn_pulse),
  .warn_ctx     (warn_ctx),
  .held         (held_vec)
);

// File: tb/tb_resv_monitor.sv
module tb_resv_monitor;
  localparam int NCTX = 4;
  localparam int AW   = 40;
  localparam int WARN = 5;
  localparam int CW   = 2;

  localparam logic [1:0] LL = 2'd1, SC = 2'd2, ST = 2'd3;
  localparam logic [AW-1:0] A = 40'h12_3456_7880;
  localparam logic [AW-1:0] B = 40'h00_0000_0A40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [CW-1:0] req_ctx = '0;
  logic [1:0] req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic req_uncached = 1'b0;
  logic rsp_valid, wr_grant, warn_pulse;
  logic [1:0] rsp_code;
  logic [CW-1:0] rsp_ctx, warn_ctx;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic g_valid, g_wr, g_warn;
  logic [1:0] g_code;
  logic [CW-1:0] g_ctx, g_wctx;

  always #5 clk = ~clk;

  resv_monitor #(.NCTX(NCTX), .AW(AW), .WARN_EVERY(WARN)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_ctx(req_ctx), .req_op(req_op), .req_addr(req_addr),
    .req_uncached(req_uncached), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .rsp_ctx(rsp_ctx), .wr_grant(wr_grant), .warn_pulse(warn_pulse),
    .warn_ctx(warn_ctx)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 20000) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'd0;
    @(posedge clk); #1;
    check("R9 ready low in reset", int'(req_ready), 0);
    check("R9 strobes low in reset", int'(rsp_valid | wr_grant | warn_pulse), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R9 ready high after reset", int'(req_ready), 1);
  endtask

  task automatic issue(input int c, input logic [1:0] op,
                       input logic [AW-1:0] a, input logic u);
    @(negedge clk);
    req_valid = 1'b1; req_ctx = CW'(c); req_op = op; req_addr = a; req_uncached = u;
    @(posedge clk); #1;
    g_valid = rsp_valid; g_code = rsp_code; g_ctx = rsp_ctx;
    g_wr = wr_grant; g_warn = warn_pulse; g_wctx = warn_ctx;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0; req_op = 2'd0; req_uncached = 1'b0;
    @(posedge clk); #1;
  endtask

  // store-conditional with checks on code, grant and response context
  task automatic sc(input string tag, input int c, input logic [AW-1:0] a,
                    input logic u, input int exp_code);
    issue(c, SC, a, u);
    check({tag, " rsp_valid"}, int'(g_valid), 1);
    check({tag, " code"}, int'(g_code), exp_code);
    check({tag, " wr_grant"}, int'(g_wr), exp_code != 0 ? 1 : 0);
    check({tag, " rsp_ctx"}, int'(g_ctx), c);
  endtask

  task automatic t_reset_state();
    do_reset();
    sc("R9 no reservation after reset", 0, A, 1'b0, 0);
    idle();
  endtask

  task automatic t_block_match();
    issue(0, LL, A, 1'b0);
    check("R11 LL no response", int'(g_valid | g_wr), 0);
    sc("R2 R4 same block other offset", 0, A + 40'hC, 1'b0, 1);
    sc("R6 own reservation cleared by own write", 0, A, 1'b0, 0);
    issue(1, LL, A, 1'b0);
    sc("R2 R3 next block fails", 1, A + 40'h10, 1'b0, 0);
    sc("R3 flag cleared by failure", 1, A, 1'b0, 0);
    idle();
  endtask

  task automatic t_store_inval();
    issue(0, LL, A + 40'h3, 1'b0);
    issue(1, LL, A + 40'hF, 1'b0);
    issue(2, LL, B, 1'b0);
    issue(3, ST, A + 40'h5, 1'b0);
    check("R11 store has no rsp_valid", int'(g_valid), 0);
    check("R11 store grants write", int'(g_wr), 1);
    sc("R6 ctx0 invalidated by store", 0, A, 1'b0, 0);
    sc("R6 ctx1 invalidated by store", 1, A, 1'b0, 0);
    sc("R6 ctx2 other block survives", 2, B, 1'b0, 1);
    idle();
  endtask

  task automatic t_replace();
    issue(0, LL, A, 1'b0);
    issue(0, LL, B, 1'b0);
    sc("R1 replaced address used", 0, B, 1'b0, 1);
    issue(0, LL, A, 1'b0);
    issue(0, LL, B, 1'b0);
    sc("R1 old address no longer held", 0, A, 1'b0, 0);
    idle();
  endtask

  task automatic t_fail_isolated();
    issue(1, LL, A, 1'b0);
    sc("R7 failing sc from ctx2", 2, A, 1'b0, 0);
    sc("R7 ctx1 keeps reservation", 1, A, 1'b0, 1);
    idle();
  endtask

  task automatic t_uncached();
    issue(0, LL, A, 1'b0);
    sc("R5 uncached sc without reservation", 1, A + 40'h8, 1'b1, 2);
    sc("R6 uncached write clears ctx0", 0, A, 1'b0, 0);
    idle();
  endtask

  task automatic fail_n(input int c, input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      sc({tag, " fail"}, c, B, 1'b0, 0);
      check({tag, " no early warning"}, int'(g_warn), 0);
    end
  endtask

  task automatic t_warning();
    do_reset();
    fail_n(3, WARN - 1, "R8");
    sc("R8 fail at multiple", 3, B, 1'b0, 0);
    check("R8 warning pulse", int'(g_warn), 1);
    check("R8 warning ctx", int'(g_wctx), 3);
    idle();
    check("R8 pulse lasts one cycle", int'(warn_pulse), 0);
    fail_n(3, WARN - 1, "R8 second window");
    sc("R8 second multiple", 3, B, 1'b0, 0);
    check("R8 second warning", int'(g_warn), 1);
    fail_n(2, 2, "R5 before uncached");
    sc("R5 uncached clears count", 2, B, 1'b1, 2);
    fail_n(2, WARN - 1, "R5 after uncached");
    sc("R5 full window after clear", 2, B, 1'b0, 0);
    check("R5 warning after full window", int'(g_warn), 1);
    check("R8 warning ctx2", int'(g_wctx), 2);
    fail_n(1, 3, "R4 before pass");
    issue(1, LL, B, 1'b0);
    sc("R4 pass", 1, B, 1'b0, 1);
    fail_n(1, WARN - 1, "R4 after pass");
    sc("R4 full window after pass", 1, B, 1'b0, 0);
    check("R4 warning after pass clears count", int'(g_warn), 1);
    idle();
  endtask

  task automatic t_back_to_back();
    issue(2, LL, A, 1'b0);
    issue(2, SC, A, 1'b0);
    check("R10 next-cycle sc sees reservation", int'(g_code), 1);
    check("R10 same-edge grant", int'(g_wr), 1);
    issue(2, SC, A, 1'b0);
    check("R10 next-cycle sc sees clear", int'(g_code), 0);
    idle();
    check("R10 response one cycle only", int'(rsp_valid), 0);
  endtask

  initial begin
    t_reset_state();
    t_block_match();
    t_store_inval();
    t_replace();
    t_fail_isolated();
    t_uncached();
    t_back_to_back();
    t_warning();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule